// File: doc/BRIEF.md
# Program-Memory Fetch Decoder with Boot Overlay

This block sits between the instruction fetch unit and the program memories of a 16-bit microcontroller. It takes each 20-bit fetch address and sends it to one of three targets: the 64 KB internal flash, a 2 KB boot ROM that can cover the top 2 KB of the flash, or the external program bus. It also returns the address within the chosen target. For every address it reports the index of the flash erase block that holds it, so an erase sequencer can aim a single-block erase. A separate input turns that index into a chip-wide code.

The block holds the boot-enable control bit. When reset is released, the bit is loaded from a stored status byte and from three strap pins. Software can then set or clear it through bit 7 of a control-register write. Setting the bit starts a cycle counter. When that count completes, the block raises a programming-voltage-ready flag. An input that marks an external high-voltage supply makes the flag available without the wait. The reset input is expected to be deasserted in step with `clk` by the reset tree.

Top module: `pmem_map_ctrl`

## Requirements
- R1: When `ea_i` is 0, `route_o` is 2 (external) and `local_addr_o` equals `fetch_addr_i`, for every address and whatever the boot-enable state. Route codes: 0 = internal flash, 1 = boot ROM, 2 = external bus.
- R2: When `ea_i` is 1 and `fetch_addr_i[19:16]` is not zero, `route_o` is 2 and `local_addr_o` equals `fetch_addr_i`.
- R3: When `ea_i` is 1, the address is in 0xF800–0xFFFF and `boot_en_o` is 1, `route_o` is 1 and `local_addr_o` is `fetch_addr_i[10:0]` with zeros above.
- R4: Every other address with `ea_i` = 1 and below 0x10000 routes to flash (`route_o` = 0), with `local_addr_o` = `fetch_addr_i[15:0]` and zeros above. This includes 0xF800–0xFFFF while `boot_en_o` is 0.
- R5: `blk_idx_o` is 0 for 0x0000–0x1FFF, 1 for 0x2000–0x3FFF, 2 for 0x4000–0x7FFF, 3 for 0x8000–0xBFFF and 4 for 0xC000–0xFFFF. It is 5 for addresses above 0xFFFF. It is 7 whenever `chip_erase_i` is 1, which takes priority. The index does not depend on `ea_i` or `boot_en_o`.
- R6: While `rst_n` is low, `boot_en_o` and `pwr_valid_o` are 0, and control writes have no effect.
- R7: At the first rising clock edge with `rst_n` high, `boot_en_o` loads 1 if `status_byte_i` is non-zero, or if `psen_n_i` = 0, `ale_i` = 1 and `ea_i` = 1. In every other case it loads 0.
- R8: After that load edge, a rising edge with `ctl_we_i` = 1 copies `ctl_wdata_i[7]` into `boot_en_o`, and the other data bits have no effect. A write presented at the load edge itself is discarded in favour of the strap value.
- R9: With `ext_hv_i` = 0, `pwr_valid_o` goes to 1 exactly `VPP_READY_CYCLES` clock edges after the edge at which `boot_en_o` rose. It stays 1 while `boot_en_o` stays 1. The count starts again from zero on every new rise of `boot_en_o`.
- R10: `pwr_valid_o` is 0 in every cycle in which `boot_en_o` is 0, including the first cycle after the bit is cleared.
- R11: While `boot_en_o` is 1 and `ext_hv_i` is 1, `pwr_valid_o` is 1 in the same cycle, without waiting for the count. With `boot_en_o` = 1, the flag falls back to the count state in the same cycle that `ext_hv_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr_i | input | 20 | Program fetch address |
| ea_i | input | 1 | Internal program memory enable (0 = all external), also sampled as a strap |
| chip_erase_i | input | 1 | Forces the chip-wide erase code on the block index |
| status_byte_i | input | 8 | Stored status byte sampled at reset release |
| psen_n_i | input | 1 | Program-strobe strap pin level |
| ale_i | input | 1 | Address-latch strap pin level |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data; bit 7 is boot enable |
| ext_hv_i | input | 1 | External high programming voltage present |
| route_o | output | 2 | Fetch target: 0 flash, 1 boot ROM, 2 external |
| local_addr_o | output | 20 | Address within the selected target |
| blk_idx_o | output | 3 | Erase block index, 5 = none, 7 = whole chip |
| boot_en_o | output | 1 | Boot-enable control bit |
| pwr_valid_o | output | 1 | Programming voltage ready flag |

## Verification
A fetch in the overlay window can arrive in the same cycle as a control write that flips the boot-enable bit. The fetch must decode with the old bit value, and the new value applies from the next edge on. The bench provokes this directly with addresses in 0xF800–0xFFFF and writes of both polarities. It also produces the case many times by chance, because random writes are mixed into a stream of addresses biased toward the top 2 KB. Each result is judged against a bench model of the bit that changes only after the edge. A second overlap, a control write at the reset-release edge, is forced and must lose to the strap value.

// File: rtl/pmem_map_pkg.sv
package pmem_map_pkg;

  typedef enum logic [1:0] {
    ROUTE_FLASH = 2'd0,
    ROUTE_BOOT  = 2'd1,
    ROUTE_EXT   = 2'd2
  } route_t;

endpackage

// File: rtl/pmem_addr_decode.sv
module pmem_addr_decode
  import pmem_map_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int FLASH_AW = 16,
  parameter int BOOT_AW  = 11,
  parameter int SMALL_AW = 13,
  parameter int LARGE_AW = 14,
  parameter int BLK_W    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ea_i,
  input  logic              boot_en_i,
  input  logic              chip_erase_i,
  output route_t            route_o,
  output logic [ADDR_W-1:0] local_addr_o,
  output logic [BLK_W-1:0]  blk_idx_o
);

  localparam int NUM_SMALL = 1 << (LARGE_AW - SMALL_AW);
  localparam int NUM_LARGE = (1 << (FLASH_AW - LARGE_AW)) - 1;
  localparam int NUM_BLK   = NUM_SMALL + NUM_LARGE;
  localparam int REG_W     = FLASH_AW - LARGE_AW;
  localparam int SUB_W     = LARGE_AW - SMALL_AW;

  logic             in_flash;
  logic             in_window;
  logic [REG_W-1:0] region;
  logic [SUB_W-1:0] sub_blk;

  assign in_flash  = (addr_i[ADDR_W-1:FLASH_AW] == '0);
  assign in_window = &addr_i[FLASH_AW-1:BOOT_AW];
  assign region    = addr_i[FLASH_AW-1:LARGE_AW];
  assign sub_blk   = addr_i[LARGE_AW-1:SMALL_AW];

  always_comb begin
    if (!ea_i || !in_flash) begin
      route_o      = ROUTE_EXT;
      local_addr_o = addr_i;
    end else if (boot_en_i && in_window) begin
      route_o      = ROUTE_BOOT;
      local_addr_o = ADDR_W'(addr_i[BOOT_AW-1:0]);
    end else begin
      route_o      = ROUTE_FLASH;
      local_addr_o = ADDR_W'(addr_i[FLASH_AW-1:0]);
    end
  end

  always_comb begin
    if (chip_erase_i) begin
      blk_idx_o = '1;
    end else if (!in_flash) begin
      blk_idx_o = BLK_W'(NUM_BLK);
    end else if (region == '0) begin
      blk_idx_o = BLK_W'(sub_blk);
    end else begin
      blk_idx_o = BLK_W'(region) + BLK_W'(NUM_SMALL - 1);
    end
  end

endmodule

// File: rtl/pmem_boot_ctrl.sv
module pmem_boot_ctrl #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       status_i,
  input  logic             psen_n_i,
  input  logic             ale_i,
  input  logic             ea_i,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             boot_en_o
);

  logic loaded_q, loaded_d;
  logic boot_en_q, boot_en_d;
  logic strap_val;
  logic boot_en_ce;

  assign strap_val  = (status_i != 8'h00) || (!psen_n_i && ale_i && ea_i);
  assign boot_en_ce = !loaded_q || we_i;

  always_comb begin
    loaded_d  = 1'b1;
    boot_en_d = boot_en_q;
    if (!loaded_q) begin
      boot_en_d = strap_val;
    end else if (we_i) begin
      boot_en_d = wdata_i[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      boot_en_q <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
      if (boot_en_ce) begin
        boot_en_q <= boot_en_d;
      end
    end
  end

  assign boot_en_o = boot_en_q;

  assert_load_strap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |=> (boot_en_o == $past(strap_val)));

  assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && we_i) |=> (boot_en_o == $past(wdata_i[EN_BIT])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !we_i) |=> $stable(boot_en_o));

endmodule

// File: rtl/pmem_vpp_timer.sv
module pmem_vpp_timer #(
  parameter int READY_CYCLES = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_en_i,
  input  logic ext_hv_i,
  output logic pwr_valid_o
);

  localparam int CNT_W = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(READY_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             done;

  assign done   = (cnt_q == CNT_LAST);
  assign cnt_ce = !boot_en_i || !done;

  always_comb begin
    if (!boot_en_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign pwr_valid_o = boot_en_i && (ext_hv_i || done);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_en_i) |-> (cnt_q == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_en_i |-> !pwr_valid_o);

  assert_ext_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_en_i && ext_hv_i) |-> pwr_valid_o);

endmodule

// File: rtl/pmem_map_ctrl.sv
module pmem_map_ctrl
  import pmem_map_pkg::*;
#(
  parameter int ADDR_W           = 20,
  parameter int FLASH_AW         = 16,
  parameter int BOOT_AW          = 11,
  parameter int SMALL_AW         = 13,
  parameter int LARGE_AW         = 14,
  parameter int CTL_W            = 8,
  parameter int EN_BIT           = 7,
  parameter int VPP_READY_CYCLES = 625,
  localparam int NUM_BLK = (1 << (LARGE_AW - SMALL_AW)) + (1 << (FLASH_AW - LARGE_AW)) - 1,
  localparam int BLK_W   = $clog2(NUM_BLK + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              ea_i,
  input  logic              chip_erase_i,
  input  logic [7:0]        status_byte_i,
  input  logic              psen_n_i,
  input  logic              ale_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              ext_hv_i,
  output logic [1:0]        route_o,
  output logic [ADDR_W-1:0] local_addr_o,
  output logic [BLK_W-1:0]  blk_idx_o,
  output logic              boot_en_o,
  output logic              pwr_valid_o
);

  route_t route;
  logic   boot_en;

  pmem_boot_ctrl #(
    .CTL_W  (CTL_W),
    .EN_BIT (EN_BIT)
  ) u_boot_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_byte_i),
    .psen_n_i  (psen_n_i),
    .ale_i     (ale_i),
    .ea_i      (ea_i),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .boot_en_o (boot_en)
  );

  pmem_vpp_timer #(
    .READY_CYCLES (VPP_READY_CYCLES)
  ) u_vpp_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_en_i   (boot_en),
    .ext_hv_i    (ext_hv_i),
    .pwr_valid_o (pwr_valid_o)
  );

  pmem_addr_decode #(
    .ADDR_W   (ADDR_W),
    .FLASH_AW (FLASH_AW),
    .BOOT_AW  (BOOT_AW),
    .SMALL_AW (SMALL_AW),
    .LARGE_AW (LARGE_AW),
    .BLK_W    (BLK_W)
  ) u_decode (
    .addr_i       (fetch_addr_i),
    .ea_i         (ea_i),
    .boot_en_i    (boot_en),
    .chip_erase_i (chip_erase_i),
    .route_o      (route),
    .local_addr_o (local_addr_o),
    .blk_idx_o    (blk_idx_o)
  );

  assign route_o   = route;
  assign boot_en_o = boot_en;

  assert_ea_low_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_i |-> (route_o == ROUTE_EXT && local_addr_o == fetch_addr_i));

  assert_high_addr_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_i && fetch_addr_i[ADDR_W-1:FLASH_AW] != '0) |-> (route_o == ROUTE_EXT));

  assert_boot_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o == ROUTE_BOOT) |-> (boot_en_o && ea_i && (&fetch_addr_i[FLASH_AW-1:BOOT_AW])));

  assert_chip_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_i |-> (blk_idx_o == '1));

  assert_reset_quiet_R6: assert property (@(posedge clk)
    !rst_n |-> (!boot_en_o && !pwr_valid_o));

endmodule

// File: tb/pmem_map_ctrl_bench.sv
`timescale 1ns/1ps
module pmem_map_ctrl_bench;

  localparam int N = 625;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] fetch_addr;
  logic        ea, chip_erase, psen_n, ale, we, ext_hv;
  logic [7:0]  status, wdata;
  logic [1:0]  route;
  logic [19:0] local_addr;
  logic [2:0]  blk_idx;
  logic        boot_en, pwr_valid;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit be_m;

  always #4 clk = ~clk;

  pmem_map_ctrl #(.VPP_READY_CYCLES(N)) u_pmem_map_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_addr_i  (fetch_addr),
    .ea_i          (ea),
    .chip_erase_i  (chip_erase),
    .status_byte_i (status),
    .psen_n_i      (psen_n),
    .ale_i         (ale),
    .ctl_we_i      (we),
    .ctl_wdata_i   (wdata),
    .ext_hv_i      (ext_hv),
    .route_o       (route),
    .local_addr_o  (local_addr),
    .blk_idx_o     (blk_idx),
    .boot_en_o     (boot_en),
    .pwr_valid_o   (pwr_valid)
  );

  function automatic logic [1:0] f_route(input logic [19:0] a, input logic e, input logic be);
    if (!e || a[19:16] != 4'h0) return 2'd2;
    if (be && a[15:11] == 5'h1F) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [19:0] f_local(input logic [19:0] a, input logic [1:0] r);
    if (r == 2'd2) return a;
    if (r == 2'd1) return {9'h0, a[10:0]};
    return {4'h0, a[15:0]};
  endfunction

  function automatic logic [2:0] f_blk(input logic [19:0] a, input logic ce);
    if (ce) return 3'd7;
    if (a[19:16] != 4'h0) return 3'd5;
    if (a < 20'h02000) return 3'd0;
    if (a < 20'h04000) return 3'd1;
    if (a < 20'h08000) return 3'd2;
    if (a < 20'h0C000) return 3'd3;
    return 3'd4;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_decode(input string tag);
    logic [1:0] er;
    er = f_route(fetch_addr, ea, be_m);
    check({30'h0, route}, {30'h0, er}, {tag, " route"});
    check({12'h0, local_addr}, {12'h0, f_local(fetch_addr, er)}, {tag, " local"});
    check({29'h0, blk_idx}, {29'h0, f_blk(fetch_addr, chip_erase)}, "R5 block index");
  endtask

  task automatic do_reset(input logic [7:0] st, input logic pn, input logic al, input logic e,
                          input logic exp_be);
    @(negedge clk);
    rst_n = 1'b0;
    status = st; psen_n = pn; ale = al; ea = e;
    we = 1'b1; wdata = 8'h80;
    repeat (2) @(negedge clk);
    check({31'h0, boot_en}, 32'h0, "R6 boot_en in reset (write ignored)");
    check({31'h0, pwr_valid}, 32'h0, "R6 pwr_valid in reset");
    we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check({31'h0, boot_en}, {31'h0, exp_be}, "R7 strap capture");
    be_m = exp_be;
    status = 8'h00; psen_n = 1'b1; ale = 1'b0; ea = 1'b1;
  endtask

  task automatic write_ctl(input logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit bad;
    void'($urandom(32'd1234));
    rst_n = 1'b0; fetch_addr = '0; ea = 1'b1; chip_erase = 1'b0;
    psen_n = 1'b1; ale = 1'b0; we = 1'b0; wdata = '0; ext_hv = 1'b0;
    status = '0; be_m = 1'b0;

    // R6, R7: reset and strap capture cases
    do_reset(8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    do_reset(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);
    do_reset(8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    do_reset(8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    do_reset(8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    do_reset(8'h01, 1'b0, 1'b1, 1'b1, 1'b1);

    // R8: write presented at the load edge loses to the strap
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    we = 1'b1; wdata = 8'h80; rst_n = 1'b1;
    @(negedge clk);
    check({31'h0, boot_en}, 32'h0, "R8 write at load edge discarded");
    @(negedge clk);
    we = 1'b0;
    check({31'h0, boot_en}, 32'h1, "R8 write after load edge");
    write_ctl(8'h7F);
    check({31'h0, boot_en}, 32'h0, "R8 only bit 7 counts (clear)");
    write_ctl(8'h80);
    check({31'h0, boot_en}, 32'h1, "R8 set by bit 7");

    // R9: exact ready delay from this rise; k=0 now
    check({31'h0, pwr_valid}, 32'h0, "R9 not ready at rise");
    bad = 1'b0;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (pwr_valid !== 1'b0) bad = 1'b1;
    end
    check({31'h0, bad}, 32'h0, "R9 low during count");
    @(negedge clk);
    check({31'h0, pwr_valid}, 32'h1, "R9 ready after count");
    repeat (5) @(negedge clk);
    check({31'h0, pwr_valid}, 32'h1, "R9 stays ready");

    // R10: clear drops flag at once
    write_ctl(8'h00);
    check({31'h0, pwr_valid}, 32'h0, "R10 drop on clear");

    // R9 restart
    write_ctl(8'h80);
    for (int k = 1; k < N; k++) @(negedge clk);
    check({31'h0, pwr_valid}, 32'h0, "R9 restart count low at N-1");
    @(negedge clk);
    check({31'h0, pwr_valid}, 32'h1, "R9 restart ready at N");

    // R11: external supply
    write_ctl(8'h00);
    ext_hv = 1'b1; #1;
    check({31'h0, pwr_valid}, 32'h0, "R10 ext supply gated by boot_en");
    write_ctl(8'h80);
    check({31'h0, pwr_valid}, 32'h1, "R11 ext supply immediate");
    ext_hv = 1'b0; #1;
    check({31'h0, pwr_valid}, 32'h0, "R11 falls back to count");
    be_m = 1'b1;

    // same-cycle write and overlay fetch
    @(negedge clk);
    fetch_addr = 20'h0F900; ea = 1'b1; we = 1'b1; wdata = 8'h00; #1;
    check({30'h0, route}, 32'h1, "R3 old bit used before edge");
    @(negedge clk);
    we = 1'b0; be_m = 1'b0;
    check({30'h0, route}, 32'h0, "R4 window goes to flash after clear");
    check({12'h0, local_addr}, 32'h0F900, "R4 flash local address");
    we = 1'b1; wdata = 8'h80; fetch_addr = 20'h0FFFF; #1;
    check({30'h0, route}, 32'h0, "R4 old bit used before edge");
    @(negedge clk);
    we = 1'b0; be_m = 1'b1;
    check_decode("R3 top of window");

    // directed corners
    fetch_addr = 20'h0F7FF; #1; check_decode("R4 below window");
    fetch_addr = 20'h10000; #1; check_decode("R2 just above flash");
    fetch_addr = 20'h01FFF; #1; check_decode("R4 block 0 end");
    fetch_addr = 20'h02000; #1; check_decode("R4 block 1 start");
    fetch_addr = 20'h0BFFF; #1; check_decode("R4 block 3 end");
    ea = 1'b0; fetch_addr = 20'h0F800; #1; check_decode("R1 ea low overrides overlay");
    chip_erase = 1'b1; #1; check_decode("R1 chip erase code");
    chip_erase = 1'b0; ea = 1'b1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom_range(0, 2);
      if (sel == 0)      fetch_addr = {9'h01F, 11'($urandom)};
      else if (sel == 1) fetch_addr = {4'h0, 16'($urandom)};
      else               fetch_addr = 20'($urandom);
      ea = ($urandom_range(0, 3) != 0);
      chip_erase = ($urandom_range(0, 7) == 0);
      we = ($urandom_range(0, 4) == 0);
      wdata = 8'($urandom);
      #1;
      if (!ea) check_decode("R1 random");
      else if (fetch_addr[19:16] != 4'h0) check_decode("R2 random");
      else if (be_m && fetch_addr[15:11] == 5'h1F) check_decode("R3 random");
      else check_decode("R4 random");
      if (we) be_m = wdata[7];
    end
    @(negedge clk);
    we = 1'b0;
    check({31'h0, boot_en}, {31'h0, be_m}, "R8 random write tracking");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule